// File: doc/BRIEF.md
# Parallel YUV Video Capture Front End

This block sits behind an 8-bit parallel camera port that carries separate horizontal and vertical sync lines. Each sync line can be enabled or ignored, and its polarity can be inverted. The block finds the leading edge of each sync and counts lines within a frame and byte clocks within a line. It then takes only the bytes inside a programmable window, given as a start offset plus a period in each direction. One byte is sampled on every clock.

Inside the window, the 4:2:2 byte stream arrives in one of four component orders. The block gathers each group of four bytes into a pixel pair in the canonical order Cb, Y0, Cr, Y1 and offers it on a valid/ready stream. A two-entry skid buffer absorbs short stalls from the consumer. When the buffer is full, a new pair is dropped and a sticky overflow flag is set.

A frame is accepted at the leading edge of vertical sync when capture is enabled and no stop is requested. A stop request lets the frame already in progress run to its end and refuses the next one. Each accepted frame produces a one-cycle start pulse. When event counting is enabled, each accepted frame also advances a running frame counter that software can poll.

Top module: `pcap_front`

## Requirements
- R1: After reset, outValid, overflowFlag and frameStartPulse are 0 and frameCount is 0.
- R2: Only data pins 9 down to 2 carry pixel data (pin 9 is the byte MSB). Pins 11, 10, 1 and 0 have no effect on outData.
- R3: With an invert bit at 0, a sync input is active high; with it at 1, the input is active low. The leading edge is the transition into the active level.
- R4: A sync input whose enable is 0 is ignored. With horizontal sync disabled, no line ever starts and no pair is output.
- R5: The byte sampled on the same clock as a horizontal sync leading edge has index 0. Bytes with index from hStart to hStart + 2*P - 1 are active, where P is hPeriod rounded up to the next even value.
- R6: The first horizontal sync leading edge after a vertical sync leading edge starts line 0. Lines vStart to vStart + vPeriod - 1 are active.
- R7: Active bytes are grouped in fours, starting at byte index hStart. orderSel gives the arrival order: 0 = Cb Y0 Cr Y1, 1 = Cr Y0 Cb Y1, 2 = Y0 Cb Y1 Cr, 3 = Y0 Cr Y1 Cb. outData packs the pair as Cb in bits 31:24, Y0 in 23:16, Cr in 15:8 and Y1 in 7:0.
- R8: While outValid is 1 and outReady is 0, outValid stays 1 and outData holds its value. Pairs leave in arrival order.
- R9: Up to two pairs wait in the buffer. A pair that completes while both entries are occupied, and no entry leaves in that cycle, is dropped. The drop sets overflowFlag, which stays 1 until reset.
- R10: A frame is accepted only if runEn is 1 and stopReq is 0 at its vertical sync leading edge. Raising stopReq after that edge does not cut short the accepted frame.
- R11: Each accepted frame gives exactly one frameStartPulse of one cycle. frameCount advances by one per accepted frame when evtEnable is 1, and holds when evtEnable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one byte per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | 12 | Data pins; bits 9:2 hold the byte |
| hsyncIn | input | 1 | Horizontal sync pin |
| vsyncIn | input | 1 | Vertical sync pin |
| hsEnable | input | 1 | Horizontal sync enable |
| vsEnable | input | 1 | Vertical sync enable |
| hsInvert | input | 1 | Horizontal sync polarity invert |
| vsInvert | input | 1 | Vertical sync polarity invert |
| orderSel | input | 2 | Input component order code |
| hStart | input | 16 | First active byte index in a line |
| hPeriod | input | 16 | Active pixels per line |
| vStart | input | 16 | First active line |
| vPeriod | input | 16 | Active lines per frame |
| runEn | input | 1 | Capture enable |
| stopReq | input | 1 | Stop after the current frame |
| evtEnable | input | 1 | Frame counter enable |
| outReady | input | 1 | Consumer ready |
| outValid | output | 1 | Pixel pair valid |
| outData | output | 32 | Pixel pair {Cb, Y0, Cr, Y1} |
| overflowFlag | output | 1 | Sticky drop indicator |
| frameStartPulse | output | 1 | One-cycle accepted-frame pulse |
| frameCount | output | 16 | Running frame event counter |

## Verification
Some properties are checked by assertions on every cycle:
- a stalled pair is held stable;
- the buffer never exceeds two entries;
- the overflow flag never clears;
- the start pulse lasts one cycle and follows an edge at which run was on and stop was off;
- the frame counter only moves by one, alongside that pulse.

Other behaviour only the bench scenarios can show. This covers the position of the window in both directions, the rounding of an odd period and the four byte orders under each sync polarity. It also covers the exact set of pairs kept and dropped under a long stall, and whether a stop request lets the running frame complete.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  // Strobes passed from sync/window control to the byte datapath.
  typedef struct packed {
    logic byteTake;    // current byte lies inside the active window
    logic groupStart;  // current byte is the first active byte of a line
    logic frameAccept; // a new frame was accepted on this cycle
  } ctrlStrobe_t;

  // Map four bytes in arrival order to {Cb, Y0, Cr, Y1}.
  function automatic logic [31:0] toCanonical(input logic [1:0] orderCode,
                                              input logic [7:0] a0,
                                              input logic [7:0] a1,
                                              input logic [7:0] a2,
                                              input logic [7:0] a3);
    logic [31:0] w;
    case (orderCode)
      2'd0:    w = {a0, a1, a2, a3};
      2'd1:    w = {a2, a1, a0, a3};
      2'd2:    w = {a1, a0, a3, a2};
      default: w = {a3, a0, a1, a2};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               hsEnable,
  input  logic               vsEnable,
  input  logic               hsInvert,
  input  logic               vsInvert,
  input  logic [CNT_W-1:0]   hStart,
  input  logic [CNT_W-1:0]   hPeriod,
  input  logic [CNT_W-1:0]   vStart,
  input  logic [CNT_W-1:0]   vPeriod,
  input  logic               runEn,
  input  logic               stopReq,
  input  logic               evtEnable,
  output ctrlStrobe_t        strobe,
  output logic               frameStartPulse,
  output logic [FRAME_W-1:0] frameCount
);
  localparam int POS_W  = CNT_W + 2;
  localparam int LINE_W = CNT_W + 1;

  logic hsQ, vsQ, hsPrev, vsPrev, hsEdge, vsEdge;
  logic [POS_W-1:0]  pixCount, posNow, hFirst, hLast;
  logic [CNT_W:0]    hEven;
  logic [LINE_W-1:0] lineCount, lineNow, vFirst, vLast;
  logic lineArmed, armedNow, lineIn, pixIn, frameActive;

  // Sync conditioning: enable gate, polarity, edge detect.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsQ <= 1'b0; vsQ <= 1'b0; hsPrev <= 1'b0; vsPrev <= 1'b0;
    end else begin
      hsQ    <= hsEnable & (hsyncIn ^ hsInvert);
      vsQ    <= vsEnable & (vsyncIn ^ vsInvert);
      hsPrev <= hsQ;
      vsPrev <= vsQ;
    end
  end
  assign hsEdge = hsQ & ~hsPrev;
  assign vsEdge = vsQ & ~vsPrev;

  // Horizontal window, odd period rounded up to even pixels.
  assign hEven  = {1'b0, hPeriod} + {{CNT_W{1'b0}}, hPeriod[0]};
  assign hFirst = {2'b00, hStart};
  assign hLast  = hFirst + {hEven, 1'b0};
  assign posNow = hsEdge ? '0 : pixCount;
  assign pixIn  = (posNow >= hFirst) && (posNow < hLast);

  // Vertical window.
  always_comb begin
    armedNow = lineArmed;
    lineNow  = lineCount;
    if (vsEdge) begin
      armedNow = 1'b0;
      lineNow  = '0;
    end else if (hsEdge) begin
      armedNow = 1'b1;
      if (!lineArmed)      lineNow = '0;
      else if (&lineCount) lineNow = lineCount;
      else                 lineNow = lineCount + LINE_W'(1);
    end
  end
  assign vFirst = {1'b0, vStart};
  assign vLast  = vFirst + {1'b0, vPeriod};
  assign lineIn = armedNow && (lineNow >= vFirst) && (lineNow < vLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCount    <= '0;
      lineCount   <= '0;
      lineArmed   <= 1'b0;
      frameActive <= 1'b0;
    end else begin
      pixCount  <= (&posNow) ? posNow : posNow + POS_W'(1);
      lineCount <= lineNow;
      lineArmed <= armedNow;
      if (vsEdge) frameActive <= runEn & ~stopReq;
    end
  end

  assign strobe.byteTake    = frameActive & lineIn & pixIn;
  assign strobe.groupStart  = (posNow == hFirst);
  assign strobe.frameAccept = vsEdge & runEn & ~stopReq;

  // Frame events.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameStartPulse <= 1'b0;
      frameCount      <= '0;
    end else begin
      frameStartPulse <= strobe.frameAccept;
      if (strobe.frameAccept && evtEnable) frameCount <= frameCount + FRAME_W'(1);
    end
  end

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameStartPulse |=> !frameStartPulse);

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (frameCount != $past(frameCount)) |->
      (frameStartPulse && frameCount == $past(frameCount) + FRAME_W'(1)));

  assert_accept_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameStartPulse |-> ($past(runEn) && !$past(stopReq)));

endmodule

// File: rtl/pcap_datapath.sv
module pcap_datapath
  import pcap_pkg::*;
#(
  parameter int SKID_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  byteIn,
  input  ctrlStrobe_t strobe,
  input  logic [1:0]  orderSel,
  input  logic        outReady,
  output logic        outValid,
  output logic [31:0] outData,
  output logic        overflowFlag
);
  localparam int PTR_W  = (SKID_DEPTH > 1) ? $clog2(SKID_DEPTH) : 1;
  localparam int FILL_W = $clog2(SKID_DEPTH + 1);

  logic [7:0]       byteQ;
  logic [1:0]       slot, curSlot;
  logic [2:0][7:0]  held;
  logic             wordDone, pop, push, drop, full;
  logic [31:0]      wordNow;
  logic [SKID_DEPTH-1:0][31:0] skidMem;
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [FILL_W-1:0] fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SKID_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // Byte gathering: aligned to the strobe timing of the control block.
  assign curSlot  = strobe.groupStart ? 2'd0 : slot;
  assign wordDone = strobe.byteTake && (curSlot == 2'd3);
  assign wordNow  = toCanonical(orderSel, held[0], held[1], held[2], byteQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteQ <= '0;
      slot  <= '0;
      held  <= '0;
    end else begin
      byteQ <= byteIn;
      if (strobe.byteTake) begin
        slot <= curSlot + 2'd1;
        if (curSlot != 2'd3) held[curSlot] <= byteQ;
      end
    end
  end

  // Two-entry skid buffer.
  assign full     = (fill == FILL_W'(SKID_DEPTH));
  assign outValid = (fill != '0);
  assign outData  = skidMem[rdPtr];
  assign pop      = outValid && outReady;
  assign push     = wordDone && (!full || pop);
  assign drop     = wordDone && full && !pop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skidMem      <= '0;
      rdPtr        <= '0;
      wrPtr        <= '0;
      fill         <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (push) begin
        skidMem[wrPtr] <= wordNow;
        wrPtr          <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: fill <= fill;
      endcase
      if (drop) overflowFlag <= 1'b1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(SKID_DEPTH));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

endmodule

// File: rtl/pcap_front.sv
module pcap_front
  import pcap_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FRAME_W    = 16,
  parameter int SKID_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        pixData,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               hsEnable,
  input  logic               vsEnable,
  input  logic               hsInvert,
  input  logic               vsInvert,
  input  logic [1:0]         orderSel,
  input  logic [CNT_W-1:0]   hStart,
  input  logic [CNT_W-1:0]   hPeriod,
  input  logic [CNT_W-1:0]   vStart,
  input  logic [CNT_W-1:0]   vPeriod,
  input  logic               runEn,
  input  logic               stopReq,
  input  logic               evtEnable,
  input  logic               outReady,
  output logic               outValid,
  output logic [31:0]        outData,
  output logic               overflowFlag,
  output logic               frameStartPulse,
  output logic [FRAME_W-1:0] frameCount
);
  ctrlStrobe_t strobe;
  logic unusedPins;

  assign unusedPins = ^{pixData[11:10], pixData[1:0]};

  pcap_ctrl #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .hsEnable(hsEnable), .vsEnable(vsEnable),
    .hsInvert(hsInvert), .vsInvert(vsInvert),
    .hStart(hStart), .hPeriod(hPeriod), .vStart(vStart), .vPeriod(vPeriod),
    .runEn(runEn), .stopReq(stopReq), .evtEnable(evtEnable),
    .strobe(strobe), .frameStartPulse(frameStartPulse), .frameCount(frameCount)
  );

  pcap_datapath #(.SKID_DEPTH(SKID_DEPTH)) data_i (
    .clk(clk), .rstN(rstN),
    .byteIn(pixData[9:2]), .strobe(strobe), .orderSel(orderSel),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .overflowFlag(overflowFlag)
  );

endmodule

// File: tb/pcap_front_tb_top.sv
module pcap_front_tb_top;
  localparam int NL  = 5;
  localparam int BPL = 20;

  logic clk = 1'b0;
  logic rstN;
  logic [11:0] pixData;
  logic hsyncIn, vsyncIn, hsEnable, vsEnable, hsInvert, vsInvert;
  logic [1:0] orderSel;
  logic [15:0] hStart, hPeriod, vStart, vPeriod;
  logic runEn, stopReq, evtEnable, outReady;
  logic outValid, overflowFlag, frameStartPulse;
  logic [31:0] outData;
  logic [15:0] frameCount;

  int nChecks = 0, nFail = 0, pulses = 0, expPulses = 0, expCount = 0;
  bit toggleRdy = 1'b0, finished = 1'b0;
  logic [31:0] expQ[$];
  logic [31:0] gotQ[$];

  always #4 clk = ~clk;

  pcap_front dut_i (
    .clk(clk), .rstN(rstN), .pixData(pixData), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .hsEnable(hsEnable), .vsEnable(vsEnable), .hsInvert(hsInvert), .vsInvert(vsInvert),
    .orderSel(orderSel), .hStart(hStart), .hPeriod(hPeriod), .vStart(vStart),
    .vPeriod(vPeriod), .runEn(runEn), .stopReq(stopReq), .evtEnable(evtEnable),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .overflowFlag(overflowFlag), .frameStartPulse(frameStartPulse), .frameCount(frameCount)
  );

  // Sample between the driving negedge and the next posedge.
  always @(negedge clk) begin
    #2;
    if (rstN === 1'b1 && outValid === 1'b1 && outReady === 1'b1) gotQ.push_back(outData);
    if (rstN === 1'b1 && frameStartPulse === 1'b1) pulses++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int fid, input int ln, input int idx);
    return 8'((fid * 37 + ln * 11 + idx * 3 + 5) & 255);
  endfunction

  // Canonical pair from four arrival bytes, by component positions.
  function automatic logic [31:0] canon(input int ord, input logic [7:0] b [4]);
    int pU, pY0, pV, pY1;
    case (ord)
      0: begin pU = 0; pY0 = 1; pV = 2; pY1 = 3; end
      1: begin pV = 0; pY0 = 1; pU = 2; pY1 = 3; end
      2: begin pY0 = 0; pU = 1; pY1 = 2; pV = 3; end
      default: begin pY0 = 0; pV = 1; pY1 = 2; pU = 3; end
    endcase
    return {b[pU], b[pY0], b[pV], b[pY1]};
  endfunction

  task automatic tick(input bit hs, input bit vs, input int fid, input int ln, input int idx);
    @(negedge clk);
    hsyncIn = hs ^ hsInvert;
    vsyncIn = vs ^ vsInvert;
    pixData = {2'(idx ^ fid), pat(fid, ln, idx), 2'(ln + idx)}; // R2: junk on unused pins
    if (toggleRdy) outReady = ~outReady;
  endtask

  task automatic sendFrame(input int fid, input bit stopMid);
    bit acc = runEn && !stopReq;
    int pe = int'(hPeriod) + int'(hPeriod % 2);
    if (acc) begin
      expPulses++;
      if (evtEnable) expCount++;
      if (hsEnable) begin
        for (int ln = 0; ln < NL; ln++) begin
          if (ln >= int'(vStart) && ln < int'(vStart) + int'(vPeriod)) begin
            for (int g = 0; g < pe / 2; g++) begin
              logic [7:0] b [4];
              for (int k = 0; k < 4; k++) b[k] = pat(fid, ln, int'(hStart) + 4 * g + k);
              expQ.push_back(canon(int'(orderSel), b));
            end
          end
        end
      end
    end
    tick(1'b0, 1'b1, fid, 99, 90);
    tick(1'b0, 1'b1, fid, 99, 91);
    tick(1'b0, 1'b0, fid, 99, 92);
    tick(1'b0, 1'b0, fid, 99, 93);
    if (stopMid) stopReq = 1'b1;
    for (int ln = 0; ln < NL; ln++)
      for (int idx = 0; idx < BPL; idx++) tick(idx == 0, 1'b0, fid, ln, idx);
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, fid, 99, 94 + i);
  endtask

  task automatic compare(input string tag);
    check(gotQ.size() == expQ.size(), tag, gotQ.size(), expQ.size());
    for (int i = 0; i < gotQ.size() && i < expQ.size(); i++)
      check(gotQ[i] === expQ[i], tag, gotQ[i], expQ[i]);
    gotQ.delete();
    expQ.delete();
  endtask

  task automatic setWin(input int hs, input int hp, input int vs, input int vp);
    hStart = 16'(hs); hPeriod = 16'(hp); vStart = 16'(vs); vPeriod = 16'(vp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    pixData = '0; hsyncIn = 1'b0; vsyncIn = 1'b0;
    hsEnable = 1'b1; vsEnable = 1'b1; hsInvert = 1'b0; vsInvert = 1'b0;
    orderSel = 2'd0; runEn = 1'b1; stopReq = 1'b0; evtEnable = 1'b1; outReady = 1'b1;
    setWin(3, 4, 1, 2);
    doReset();
    #2;
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid", 32'(outValid), 0);
    check(overflowFlag == 1'b0, "R1 overflowFlag", 32'(overflowFlag), 0);
    check(frameStartPulse == 1'b0, "R1 frameStartPulse", 32'(frameStartPulse), 0);
    check(frameCount == 16'd0, "R1 frameCount", 32'(frameCount), 0);

    // R2 R3 R5 R6 R7: sweep orders, polarities and windows (R5 odd period rounding)
    for (int ord = 0; ord < 4; ord++) begin
      for (int inv = 0; inv < 4; inv++) begin
        @(negedge clk);
        orderSel = 2'(ord);
        hsInvert = inv[0]; vsInvert = inv[1];
        hsyncIn = hsInvert; vsyncIn = vsInvert;
        case ((ord + inv) % 3)
          0: setWin(3, 4, 1, 2);
          1: setWin(0, 3, 0, 1);
          default: setWin(5, 1, 2, 3);
        endcase
        sendFrame(ord * 4 + inv, 1'b0);
        compare("R7 R3 R5 R6 order/polarity/window sweep");
      end
    end
    check(frameCount == 16'(expCount), "R11 frameCount after sweep", 32'(frameCount), 32'(expCount));
    check(pulses == expPulses, "R11 pulse count after sweep", 32'(pulses), 32'(expPulses));

    // R8: consumer toggling ready, order preserved
    setWin(1, 4, 0, 3);
    toggleRdy = 1'b1;
    sendFrame(40, 1'b0);
    toggleRdy = 1'b0;
    @(negedge clk); outReady = 1'b1;
    repeat (4) @(negedge clk);
    compare("R8 toggling ready");

    // R4: horizontal sync disabled gives no output
    hsEnable = 1'b0;
    sendFrame(41, 1'b0);
    compare("R4 hsync disabled");
    hsEnable = 1'b1;

    // R11: event counting off holds the counter, pulse still given
    evtEnable = 1'b0;
    sendFrame(42, 1'b0);
    compare("R11 evt off frame data");
    check(frameCount == 16'(expCount), "R11 counter held", 32'(frameCount), 32'(expCount));
    check(pulses == expPulses, "R11 pulse with evt off", 32'(pulses), 32'(expPulses));
    evtEnable = 1'b1;

    // R10: stop after accepted edge lets frame finish; next frame refused
    sendFrame(43, 1'b1);
    compare("R10 frame completes after stop");
    sendFrame(44, 1'b0);
    compare("R10 frame refused while stopped");
    stopReq = 1'b0;
    runEn = 1'b0;
    sendFrame(45, 1'b0);
    compare("R10 frame refused while run off");
    runEn = 1'b1;
    check(frameCount == 16'(expCount), "R10 R11 frameCount", 32'(frameCount), 32'(expCount));
    check(pulses == expPulses, "R10 R11 pulses", 32'(pulses), 32'(expPulses));

    // R9: stall the consumer over four pairs; first two kept, rest dropped
    check(overflowFlag == 1'b0, "R9 no overflow before stall", 32'(overflowFlag), 0);
    setWin(2, 4, 1, 2);
    @(negedge clk); outReady = 1'b0;
    sendFrame(46, 1'b0);
    #2;
    check(expQ.size() == 4, "R9 four pairs expected", expQ.size(), 4);
    check(outValid == 1'b1, "R8 valid held under stall", 32'(outValid), 1);
    check(outData === expQ[0], "R8 data held under stall", outData, expQ[0]);
    check(overflowFlag == 1'b1, "R9 overflow set", 32'(overflowFlag), 1);
    repeat (3) @(negedge clk);
    #2;
    check(outData === expQ[0], "R8 data still held", outData, expQ[0]);
    expQ = expQ[0:1];
    @(negedge clk); outReady = 1'b1;
    repeat (6) @(negedge clk);
    compare("R9 only first two pairs survive");
    #2;
    check(overflowFlag == 1'b1, "R9 overflow sticky", 32'(overflowFlag), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule